// File: doc/BRIEF.md
# Bit-Settable GPIO Controller with Pin Interrupts

This block controls sixteen general-purpose pins from a plain valid/write/address/data register bus. Each pin is an input or an output according to its own direction bit. Software changes output levels through a set port and a clear port. A write to either port touches only the bits written as one, so several tasks can each drive their own pins without a read-modify-write sequence.

Every pin has a sensed value. For an input this is the pin level after a two-flop synchronizer. For an output it is the level the block drives. The sensed value can raise an interrupt. Each pin is either level-sensitive (active while high) or edge-sensitive. An edge-sensitive pin reacts to rising edges only, or to both edges. An edge sets a sticky per-pin latch that software acknowledges by writing a one to it. Interrupt enables also change only through their own set and clear ports. The single `irq` output is the OR of all enabled pins whose condition is active.

Top module: `gpio_bitset`

## Requirements
- R1: After reset every register reads zero, so all pins are inputs (`pin_oe` = 0) with outputs low, all interrupts are disabled and `irq` is 0.
- R2: Address 0 holds the direction word, which can be read and written (1 = output). `pin_oe` equals it and `pin_out` presents the output register.
- R3: A write to address 1 sets each output bit whose written bit is 1 and leaves the others unchanged. Addresses 1 and 2 both read back the output register.
- R4: A write to address 2 clears each output bit whose written bit is 1 and leaves the others unchanged.
- R5: Address 3 returns the sensed value of each pin. An output pin shows its driven level at once. An input pin shows `pin_in` after exactly two clock edges.
- R6: A write to address 4 sets the interrupt-enable bits written as 1, and a write to address 5 clears them. Both addresses read back the enable word.
- R7: A pin whose bit at address 6 is 0 is level-sensitive. It requests an interrupt for as long as its sensed value is high.
- R8: A pin whose bit at address 6 is 1 and bit at address 7 is 0 latches a rising edge of its sensed value. A falling edge is ignored. The latch holds until it is acknowledged.
- R9: A pin whose bits at addresses 6 and 7 are both 1 latches rising and falling edges alike.
- R10: Address 8 reads the edge latches. Writing 1 to a bit there clears that latch, unless a new edge is detected in the same cycle, in which case the latch stays set.
- R11: `irq` is high exactly when some pin is both enabled and active, where active means the level is high or the latch is set. Active pins that are not enabled do not raise `irq`.
- R12: An output pin raises interrupts from the value software drives on it, under the same level and edge rules as an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register (combinational) |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Output levels to drive |
| pin_oe | output | 16 | Per-pin output enable (direction) |
| irq | output | 1 | Combined interrupt request |

## Verification
The set and clear ports are tested with overlapping and disjoint masks, which shows that unwritten bits keep their value. Status is read one and two cycles after an input change, to separate the synchronizer delay from a wrong depth. The interrupt paths use a level pin, a rising-only pin and a both-edge pin on the same waveforms, so falling-edge handling shows up as a difference between modes. An acknowledgement written in the very cycle a new edge arrives confirms that the edge wins. An output pin toggled by software checks that driven values raise interrupts.

// File: rtl/gpio_bitset.sv
module gpio_bitset #(
  parameter int NPINS = 16,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  localparam logic [AW-1:0] A_DIR  = AW'(0);
  localparam logic [AW-1:0] A_OSET = AW'(1);
  localparam logic [AW-1:0] A_OCLR = AW'(2);
  localparam logic [AW-1:0] A_STAT = AW'(3);
  localparam logic [AW-1:0] A_ESET = AW'(4);
  localparam logic [AW-1:0] A_ECLR = AW'(5);
  localparam logic [AW-1:0] A_EDGE = AW'(6);
  localparam logic [AW-1:0] A_BOTH = AW'(7);
  localparam logic [AW-1:0] A_ACK  = AW'(8);

  logic [NPINS-1:0] dir_q, out_q, ien_q, edge_q, both_q;
  logic [NPINS-1:0] sync1_q, sync2_q, prev_q, latch_q;
  logic [NPINS-1:0] sense, ev, active, ack_mask;
  logic             wr;

  assign wr       = bus_valid & bus_write;
  assign ack_mask = (wr && bus_addr == A_ACK) ? bus_wdata : '0;

  assign sense  = (dir_q & out_q) | (~dir_q & sync2_q);
  assign ev     = edge_q & ((sense & ~prev_q) | (both_q & ~sense & prev_q));
  assign active = (edge_q & latch_q) | (~edge_q & sense);
  assign irq    = |(active & ien_q);

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      ien_q   <= '0;
      edge_q  <= '0;
      both_q  <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sense;
      latch_q <= (latch_q & ~ack_mask) | ev;
      if (wr) begin
        case (bus_addr)
          A_DIR:  dir_q  <= bus_wdata;
          A_OSET: out_q  <= out_q | bus_wdata;
          A_OCLR: out_q  <= out_q & ~bus_wdata;
          A_ESET: ien_q  <= ien_q | bus_wdata;
          A_ECLR: ien_q  <= ien_q & ~bus_wdata;
          A_EDGE: edge_q <= bus_wdata;
          A_BOTH: both_q <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_DIR:          bus_rdata = dir_q;
      A_OSET, A_OCLR: bus_rdata = out_q;
      A_STAT:         bus_rdata = sense;
      A_ESET, A_ECLR: bus_rdata = ien_q;
      A_EDGE:         bus_rdata = edge_q;
      A_BOTH:         bus_rdata = both_q;
      A_ACK:          bus_rdata = latch_q;
      default:        bus_rdata = '0;
    endcase
  end

  AST_OUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_OSET) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata))); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && (bus_addr == A_OSET || bus_addr == A_OCLR)) |=> $stable(pin_out)); // R3
  AST_OUT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_OCLR) |=> ((pin_out & $past(bus_wdata)) == '0)); // R4
  AST_IEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_ESET) |=> ((ien_q & $past(bus_wdata)) == $past(bus_wdata))); // R6
  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && bus_addr == A_ACK) |=> ((latch_q & $past(latch_q)) == $past(latch_q))); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq); // R11
endmodule

// File: tb/test_gpio_bitset.sv
module test_gpio_bitset;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  logic        irq;

  gpio_bitset i_gpio_bitset (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          sel;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic expect_item(input int sel, input logic [3:0] a, input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_valid = (sel == 0); bus_write = 0; bus_addr = a;
    it.sel = sel; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
    expect_item(0, a, e, tag);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    expect_item(1, 4'd0, {15'd0, e}, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = q.pop_front();
        case (it.sel)
          0: act = bus_rdata;
          1: act = {15'd0, irq};
          2: act = pin_out;
          default: act = pin_oe;
        endcase
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    idle(2);
    rst_n = 1;
    // R1 reset state
    rd(4'd0, 16'h0000, "R1 dir");
    rd(4'd1, 16'h0000, "R1 out");
    rd(4'd4, 16'h0000, "R1 ien");
    rd(4'd6, 16'h0000, "R1 edge");
    rd(4'd8, 16'h0000, "R1 latch");
    expect_item(3, 4'd0, 16'h0000, "R1 pin_oe");
    chk_irq(1'b0, "R1 irq");
    // R2 direction
    wr(4'd0, 16'h00F0);
    expect_item(3, 4'd0, 16'h00F0, "R2 pin_oe");
    rd(4'd0, 16'h00F0, "R2 dir readback");
    // R3 set port
    wr(4'd1, 16'h0033);
    wr(4'd1, 16'h0100);
    expect_item(2, 4'd0, 16'h0133, "R3 pin_out after two sets");
    // R4 clear port
    wr(4'd2, 16'h0011);
    rd(4'd1, 16'h0122, "R4 out after clear");
    rd(4'd2, 16'h0122, "R3 readback at clear address");
    // R5 status timing
    @(negedge clk); pin_in = 16'h8001;
    rd(4'd3, 16'h0020, "R5 status one edge after input change");
    rd(4'd3, 16'h8021, "R5 status two edges after input change");
    pin_in = 16'h0000;
    wr(4'd2, 16'hFFFF);
    wr(4'd0, 16'h0000);
    idle(3);
    // R6 enables
    wr(4'd4, 16'h0005);
    rd(4'd4, 16'h0005, "R6 enable set");
    wr(4'd5, 16'h0001);
    rd(4'd5, 16'h0004, "R6 enable clear");
    // R7 level
    @(negedge clk); pin_in = 16'h0004;
    idle(3);
    chk_irq(1'b1, "R7 level high raises irq");
    @(negedge clk); pin_in = 16'h0000;
    idle(3);
    chk_irq(1'b0, "R7 level low drops irq");
    // R11 masked pin
    @(negedge clk); pin_in = 16'h0008;
    idle(3);
    chk_irq(1'b0, "R11 disabled pin gives no irq");
    rd(4'd3, 16'h0008, "R11 pin seen in status");
    @(negedge clk); pin_in = 16'h0000;
    idle(3);
    // R8 rising only on pin 1
    wr(4'd6, 16'h0002);
    wr(4'd4, 16'h0002);
    @(negedge clk); pin_in = 16'h0002;
    idle(3);
    rd(4'd8, 16'h0002, "R8 rising edge latched");
    chk_irq(1'b1, "R11 enabled latch raises irq");
    wr(4'd8, 16'h0002);
    rd(4'd8, 16'h0000, "R10 acknowledge clears latch");
    chk_irq(1'b0, "R8 irq gone after ack while pin high");
    @(negedge clk); pin_in = 16'h0000;
    idle(3);
    rd(4'd8, 16'h0000, "R8 falling edge ignored");
    // R9 both edges
    wr(4'd7, 16'h0002);
    @(negedge clk); pin_in = 16'h0002;
    idle(3);
    wr(4'd8, 16'h0002);
    @(negedge clk); pin_in = 16'h0000;
    idle(3);
    rd(4'd8, 16'h0002, "R9 falling edge latched");
    wr(4'd8, 16'h0002);
    // R10 same-cycle edge wins
    @(negedge clk); pin_in = 16'h0002;
    @(negedge clk);
    wr(4'd8, 16'h0002);
    rd(4'd8, 16'h0002, "R10 new edge beats acknowledge");
    wr(4'd8, 16'h0002);
    rd(4'd8, 16'h0000, "R10 later acknowledge clears");
    // R12 output pin 5 rising edge
    wr(4'd5, 16'hFFFF);
    wr(4'd0, 16'h0020);
    wr(4'd6, 16'h0022);
    wr(4'd4, 16'h0020);
    wr(4'd1, 16'h0020);
    rd(4'd8, 16'h0020, "R12 driven output edge latched");
    chk_irq(1'b1, "R12 driven output raises irq");
    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule